// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers interrupt requests from six sources into latches that only hardware sets: two external pins, a high-speed timer, timer A, timer B and a time base. Each source other than the first passes through a software mask bit. A global enable gates everything. The controller picks the highest-priority eligible source and offers the CPU a 12-bit entry address together with an interrupt request. The CPU takes the interrupt with a one-cycle accept handshake. In that cycle the controller pulses a save-context strobe, which asks the CPU to push PC and flags, and a status-force strobe, which sets the status flag to 1. On the following edge it clears the accepted source's latch and drops the global enable. A return-from-interrupt strobe turns the enable back on.

The global enable is held as a three-state machine:
- ST_MASKED: software has turned the enable off. This is also the reset state.
- ST_ENABLED: interrupts may be raised.
- ST_SERVICING: the enable was dropped automatically by an acceptance, and the controller waits for the return.

Transitions are checked in this order:
- T_ACCEPT: ST_ENABLED goes to ST_SERVICING on accept while irq is high.
- T_RETURN: any state goes to ST_ENABLED on the return strobe.
- T_SW_ON: a software enable write with value 1 goes to ST_ENABLED.
- T_SW_OFF: a software enable write with value 0 goes to ST_MASKED.

Software can also clear latches and write the masks. The stack and the program counter belong to the CPU.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all latches, all masks and the global enable are 0. `irq` is 0 and `vector` is 0.
- R2: A high `src_req[i]` sets latch i at the next clock edge. This holds even when a software clear or an acceptance clears the same latch in that cycle.
- R3: A software clear (`lat_clr_we` with bit i of `lat_clr_mask` set) clears latch i at the next edge. No software input can set a latch. `pending` shows the latches.
- R4: Source encoding is bit 0 = INT0, 1 = high-speed timer, 2 = timer A, 3 = timer B, 4 = time base, 5 = INT1. Mask bit i = 1 permits source i for i from 1 to 5. INT0 is always permitted, so `mask_wdata[0]` has no effect.
- R5: `irq` is high exactly when the state is ST_ENABLED and at least one latched source is permitted.
- R6: When several permitted sources are latched, the one with the lowest bit index wins.
- R7: `vector` equals 0x002 + 2 × (index of the winning source), giving 0x002 up to 0x00C. It is 0 when no source is eligible.
- R8: `accept` while `irq` is high pulses `save_ctx` and `status_set` in that same cycle. At the next edge the winning latch clears and the state moves to ST_SERVICING, so `irq` falls.
- R9: `accept` while `irq` is low is ignored. No strobe fires, and no latch or state changes.
- R10: `reti` moves the state to ST_ENABLED. A software enable write moves it to ST_ENABLED (value 1) or ST_MASKED (value 0). Acceptance outranks `reti`, and `reti` outranks the software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 6 | Hardware request per source |
| lat_clr_we | input | 1 | Software latch-clear strobe |
| lat_clr_mask | input | 6 | Latches to clear |
| mask_we | input | 1 | Software mask write strobe |
| mask_wdata | input | 6 | New mask value (1 = permit) |
| gie_we | input | 1 | Software global enable write strobe |
| gie_wdata | input | 1 | New global enable value |
| reti | input | 1 | Return-from-interrupt strobe |
| accept | input | 1 | CPU accepts the offered interrupt |
| irq | output | 1 | Interrupt request to the CPU |
| vector | output | 12 | Entry address of the winning source |
| save_ctx | output | 1 | Push PC and flags (accept cycle) |
| status_set | output | 1 | Force status flag to 1 (accept cycle) |
| pending | output | 6 | Current latch contents |

## Verification
The bench builds the block with its default parameters: six sources, a 12-bit vector, a base of 0x002 and a step of 2. With these values every entry address from 0x002 to 0x00C can be reached. The bench walks a three-way collision through successive accept and return rounds. It also covers the unmaskable first source with all masks at 0, and a same-cycle race between a hardware request and a software clear. Finally it drives an accept against a masked enable and checks that nothing changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_MASKED    = 2'd0,
        ST_ENABLED   = 2'd1,
        ST_SERVICING = 2'd2
    } gie_state_t;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               lat_clr_we,
    input  logic [NUM_SRC-1:0] lat_clr_mask,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic [NUM_SRC-1:0] lat_q
);
    logic [NUM_SRC-1:0] sw_clr;

    always_comb begin
        sw_clr = lat_clr_we ? lat_clr_mask : '0;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lat
        always_ff @(posedge clk) begin
            if (!rst_n)
                lat_q[i] <= 1'b0;
            else if (src_req[i])
                lat_q[i] <= 1'b1;
            else if (sw_clr[i] || ack_clr[i])
                lat_q[i] <= 1'b0;
        end

        // R2: a hardware request always lands in its latch
        assert_req_sets_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> lat_q[i]);

        // R8: an accepted source leaves its latch empty unless re-requested
        assert_ack_clears_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[i] && !src_req[i]) |=> !lat_q[i]);

        // R3: software clear empties the latch when no request races it
        assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_clr_we && lat_clr_mask[i] && !src_req[i]) |=> !lat_q[i]);
    end
endmodule

// File: rtl/irq_priority.sv
module irq_priority #(
    parameter int              NUM_SRC  = 6,
    parameter int              VEC_W    = 12,
    parameter logic [VEC_W-1:0] VEC_BASE = 12'h002,
    parameter int              VEC_STEP = 2,
    parameter logic [NUM_SRC-1:0] ALWAYS_ON = 6'b000001
) (
    input  logic [NUM_SRC-1:0] lat_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] grant,
    output logic               any_eligible,
    output logic [VEC_W-1:0]   vector
);
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC:0]   taken;

    always_comb begin
        eligible = lat_q & (mask_q | ALWAYS_ON);
    end

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign grant[i]   = eligible[i] & ~taken[i];
        assign taken[i+1] = taken[i] | eligible[i];
    end

    assign any_eligible = taken[NUM_SRC];

    always_comb begin
        vector = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (grant[k])
                vector = VEC_BASE + VEC_W'(VEC_STEP * k);
        end
    end

    // R6: at most one source wins at a time
    always_comb begin
        assert_grant_onehot_R6: assert ($onehot0(grant));
    end
    // R4: a winner must be latched and permitted
    always_comb begin
        assert_grant_permitted_R4: assert ((grant & ~(lat_q & (mask_q | ALWAYS_ON))) == '0);
    end
endmodule

// File: rtl/irq_gie_fsm.sv
module irq_gie_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_fire,
    input  logic reti,
    input  logic gie_we,
    input  logic gie_wdata,
    output logic gie_on,
    output gie_state_t state_q
);
    gie_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ENABLED: begin
                if (accept_fire)            state_d = ST_SERVICING;  // T_ACCEPT
                else if (reti)              state_d = ST_ENABLED;    // T_RETURN
                else if (gie_we && !gie_wdata) state_d = ST_MASKED;  // T_SW_OFF
            end
            ST_MASKED, ST_SERVICING: begin
                if (reti)                   state_d = ST_ENABLED;    // T_RETURN
                else if (gie_we)            state_d = gie_wdata ? ST_ENABLED : ST_MASKED;
            end
            default:                        state_d = ST_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        gie_on = (state_q == ST_ENABLED);
    end

    // R8: acceptance drops the global enable
    assert_accept_drops_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_fire |=> state_q == ST_SERVICING);
    // R10: return strobe restores the enable
    assert_reti_sets_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !accept_fire) |=> state_q == ST_ENABLED);
    // R10: software off-write takes effect when nothing outranks it
    assert_sw_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_we && !gie_wdata && !reti && !accept_fire) |=> state_q == ST_MASKED);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               lat_clr_we,
    input  logic [NUM_SRC-1:0] lat_clr_mask,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               gie_we,
    input  logic               gie_wdata,
    input  logic               reti,
    input  logic               accept,
    output logic               irq,
    output logic [VEC_W-1:0]   vector,
    output logic               save_ctx,
    output logic               status_set,
    output logic [NUM_SRC-1:0] pending
);
    localparam logic [NUM_SRC-1:0] ALWAYS_ON = NUM_SRC'(1);
    localparam logic [VEC_W-1:0]   BASE_V    = VEC_W'(VEC_BASE);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] lat_q;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] ack_clr;
    logic               any_eligible;
    logic               gie_on;
    logic               accept_fire;
    gie_state_t         state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_comb begin
        irq         = gie_on & any_eligible;
        accept_fire = irq & accept;
        ack_clr     = accept_fire ? grant : '0;
        save_ctx    = accept_fire;
        status_set  = accept_fire;
        pending     = lat_q;
    end

    irq_latch_bank #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_req      (src_req),
        .lat_clr_we   (lat_clr_we),
        .lat_clr_mask (lat_clr_mask),
        .ack_clr      (ack_clr),
        .lat_q        (lat_q)
    );

    irq_priority #(
        .NUM_SRC   (NUM_SRC),
        .VEC_W     (VEC_W),
        .VEC_BASE  (BASE_V),
        .VEC_STEP  (VEC_STEP),
        .ALWAYS_ON (ALWAYS_ON)
    ) u_prio (
        .lat_q        (lat_q),
        .mask_q       (mask_q),
        .grant        (grant),
        .any_eligible (any_eligible),
        .vector       (vector)
    );

    irq_gie_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_fire (accept_fire),
        .reti        (reti),
        .gie_we      (gie_we),
        .gie_wdata   (gie_wdata),
        .gie_on      (gie_on),
        .state_q     (state_q)
    );

    // R9: no strobe without a raised request
    assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> !save_ctx && !status_set);
    // R7: a raised request always carries a nonzero entry address
    assert_vector_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vector != '0);
    // R5: request only while the enable state is on
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> state_q == ST_ENABLED);
    // R9: an ignored accept leaves latches untouched
    assert_ignored_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !irq && !lat_clr_we) |=> (lat_q & $past(lat_q)) == $past(lat_q));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int N = 6;
    localparam time HALF = 2.5ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic          lat_clr_we = 1'b0;
    logic [N-1:0]  lat_clr_mask = '0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          gie_we = 1'b0;
    logic          gie_wdata = 1'b0;
    logic          reti = 1'b0;
    logic          accept = 1'b0;
    logic          irq;
    logic [11:0]   vector;
    logic          save_ctx;
    logic          status_set;
    logic [N-1:0]  pending;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .lat_clr_we(lat_clr_we), .lat_clr_mask(lat_clr_mask),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .gie_we(gie_we), .gie_wdata(gie_wdata),
        .reti(reti), .accept(accept),
        .irq(irq), .vector(vector), .save_ctx(save_ctx),
        .status_set(status_set), .pending(pending)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance one edge, then release all strobes away from the edge
    task automatic step();
        @(posedge clk);
        #1;
        src_req = '0; lat_clr_we = 0; mask_we = 0; gie_we = 0;
        reti = 0; accept = 0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        chk("R1 pending", pending, 0);
        chk("R1 irq", irq, 0);
        chk("R1 vector", vector, 0);
    endtask

    task automatic t_unmaskable();
        src_req = 6'b000001; step();
        chk("R2 latch set", pending, 6'b000001);
        chk("R5 no irq while masked", irq, 0);
        gie_we = 1; gie_wdata = 1; step();
        chk("R4 INT0 ignores zero mask", irq, 1);
        chk("R7 vector INT0", vector, 12'h002);
    endtask

    task automatic t_accept();
        accept = 1; #1;
        chk("R8 save_ctx", save_ctx, 1);
        chk("R8 status_set", status_set, 1);
        step();
        chk("R8 latch cleared", pending, 0);
        chk("R8 irq dropped", irq, 0);
        src_req = 6'b000001; step();
        chk("R8 enable off in service", irq, 0);
        reti = 1; step();
        chk("R10 reti re-enables", irq, 1);
        chk("R10 vector", vector, 12'h002);
        accept = 1; step();
        reti = 1; step();
        chk("R8 second accept cleared", pending, 0);
    endtask

    task automatic t_mask();
        src_req = 6'b000100; step();
        chk("R4 masked latched", pending, 6'b000100);
        chk("R4 masked no irq", irq, 0);
        mask_we = 1; mask_wdata = 6'b000100; step();
        chk("R4 permitted irq", irq, 1);
        chk("R7 vector timer A", vector, 12'h006);
    endtask

    task automatic t_priority();
        mask_we = 1; mask_wdata = 6'b111110;
        src_req = 6'b100010; step();
        chk("R6 pending three", pending, 6'b100110);
        chk("R6 highest wins", vector, 12'h004);
        accept = 1; step();
        chk("R8 only winner cleared", pending, 6'b100100);
        reti = 1; step();
        chk("R6 next winner", vector, 12'h006);
        accept = 1; step();
        reti = 1; step();
        chk("R7 vector INT1", vector, 12'h00C);
        accept = 1; step();
        reti = 1; step();
        chk("R7 none eligible vector", vector, 0);
        chk("R5 none eligible irq", irq, 0);
    endtask

    task automatic t_swclear();
        src_req = 6'b010000; step();
        chk("R7 vector time base", vector, 12'h00A);
        lat_clr_we = 1; lat_clr_mask = 6'b010000; step();
        chk("R3 sw clear", pending, 0);
        chk("R3 irq gone", irq, 0);
        src_req = 6'b001000; step();
        src_req = 6'b001000; lat_clr_we = 1; lat_clr_mask = 6'b001000; step();
        chk("R2 request beats clear", pending, 6'b001000);
        lat_clr_we = 1; lat_clr_mask = 6'b111111; step();
        chk("R3 clear all", pending, 0);
    endtask

    task automatic t_ignored();
        gie_we = 1; gie_wdata = 0; step();
        src_req = 6'b000001; step();
        accept = 1; #1;
        chk("R9 no save_ctx", save_ctx, 0);
        chk("R9 no status_set", status_set, 0);
        step();
        chk("R9 latch kept", pending, 6'b000001);
        gie_we = 1; gie_wdata = 1; step();
        chk("R10 sw enable", irq, 1);
        gie_we = 1; gie_wdata = 0; reti = 1; step();
        chk("R10 reti beats sw write", irq, 1);
    endtask

    initial begin
        #1;
        t_reset();
        t_unmaskable();
        t_accept();
        t_mask();
        t_priority();
        t_swclear();
        t_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule